// File: doc/BRIEF.md
# TLB-Miss Page Access Filter and Logger

This block sits on the miss side of a translation lookaside buffer. Each time the TLB misses, the missing virtual page number is offered to the block through a valid/ready handshake. The block holds a small fully associative set of recently missed pages. A page found in that set is filtered: it is absorbed and produces no record. A page not found is installed in the set, and its page number is written out as one record of an access trace. The trace lives in memory between a base pointer and a limit pointer. Records go out through a simple one-word write port.

When the record at the last address below the limit is written, an overflow interrupt is raised. While the interrupt is pending, pages that would need a record are held off by dropping ready. Filtered pages keep flowing. A one-cycle clear pulse drops the interrupt and rewinds the write pointer to the base. A flush input empties the filtering set in a single cycle.

The size of the filtering set is a parameter with a default of 2048 entries. It is fixed by that parameter, not by the amount of physical memory. A larger set filters more misses and writes fewer records, but the trace it leaves is less exact.

Top module: `tlbmiss_filter_logger`

## Requirements
- R1: After reset, `irq` is 0, `log_wr_en` is 0, the filtering set is empty, and `miss_ready` is 1 while `flush` and `irq_clear` are low.
- R2: A page is consumed only in a cycle where both `miss_valid` and `miss_ready` are 1. A page presented with `miss_valid` low causes no record and is not installed.
- R3: A consumed page that is already held in the set causes no record and leaves the write pointer unchanged.
- R4: A consumed page that is not held in the set is installed. In the next cycle, `log_wr_en` is 1 for exactly one cycle, with `log_wr_data` equal to the page and `log_wr_addr` equal to the write pointer. The write pointer starts at `log_base` and advances by 1 per record.
- R5: An install uses the lowest-indexed empty slot if one exists. Otherwise it replaces the least recently used page. Both filtered pages and installed pages become the most recently used.
- R6: `irq` becomes 1 on the same clock edge that presents the record at address `log_limit - 1`. The capacity of the log is `log_limit - log_base` records.
- R7: While `irq` is 1, a page not held in the set sees `miss_ready` low and produces no record. A page held in the set is still accepted and filtered.
- R8: A one-cycle `irq_clear` makes `irq` 0 from the next cycle and returns the write pointer to `log_base`. During the clear cycle, `miss_ready` is low for pages not held in the set.
- R9: A one-cycle `flush` empties the whole set, so every page misses afterwards. `miss_ready` is low during the flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the filtering set |
| miss_valid | input | 1 | A TLB-miss page is offered |
| miss_vpn | input | VPN_W | Virtual page number of the TLB miss |
| miss_ready | output | 1 | Offered page can be consumed this cycle |
| log_base | input | AW | First record address of the log |
| log_limit | input | AW | One past the last record address |
| log_wr_en | output | 1 | Record write strobe |
| log_wr_addr | output | AW | Record address |
| log_wr_data | output | VPN_W | Record contents (page number) |
| irq | output | 1 | Log-full interrupt |
| irq_clear | input | 1 | Acknowledge pulse: drop interrupt, rewind pointer |

## Verification
The assertions assume three things about the inputs. `log_base` and `log_limit` stay constant between resets, and `log_limit` is greater than `log_base`. `flush` and `irq_clear` are single-cycle pulses that never coincide. The bench fixes the pointers at 16 and 24 for the whole run and raises each pulse for exactly one cycle on its own. It drives page numbers only at falling edges, with the set reduced to four entries so that eviction order can be predicted by hand.

// File: rtl/afl_pkg.sv
package afl_pkg;

    // Kind of update applied to the filtering set in a cycle
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_HIT    = 2'd1,
        ACT_INSERT = 2'd2
    } act_e;

    // An entry ages when it is valid and more recent than the reference age
    function automatic logic ages_after(input logic valid,
                                        input int unsigned age,
                                        input int unsigned ref_age);
        return valid && (age < ref_age);
    endfunction

endpackage

// File: rtl/afl_active_set.sv
module afl_active_set
    import afl_pkg::*;
#(
    parameter int ENTRIES = 2048,
    parameter int VPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  act_e             act,
    input  logic [VPN_W-1:0] vpn,
    output logic             hit
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

    logic             valid_q [ENTRIES];
    logic [VPN_W-1:0] tag_q   [ENTRIES];
    logic [IDX_W-1:0] age_q   [ENTRIES];
    logic [ENTRIES-1:0] match;

    logic [IDX_W-1:0] hit_idx, hit_age, free_idx, old_idx, tgt_idx, ref_age;
    logic             free_found;

    // Lowest index wins for both the matching slot and the empty slot
    always_comb begin
        hit_idx    = '0;
        hit_age    = '0;
        free_found = 1'b0;
        free_idx   = '0;
        old_idx    = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
                hit_age = age_q[i];
            end
            if (!valid_q[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (valid_q[i] && age_q[i] == AGE_MAX) begin
                old_idx = IDX_W'(i);
            end
        end
    end

    assign hit     = |match;
    assign tgt_idx = hit ? hit_idx : (free_found ? free_idx : old_idx);
    // Valid ages form a permutation 0..n-1, so AGE_MAX ages every other entry
    assign ref_age = hit ? hit_age : AGE_MAX;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign match[g] = valid_q[g] && (tag_q[g] == vpn);

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                valid_q[g] <= 1'b0;
                age_q[g]   <= '0;
            end else if (act != ACT_NONE) begin
                if (tgt_idx == IDX_W'(g)) begin
                    valid_q[g] <= 1'b1;
                    age_q[g]   <= '0;
                end else if (ages_after(valid_q[g], 32'(age_q[g]), 32'(ref_age))) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (act == ACT_INSERT && tgt_idx == IDX_W'(g)) begin
                tag_q[g] <= vpn;
            end
        end
    end

    // R3: a page can sit in at most one slot
    p_one_match_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/afl_log_ctrl.sv
module afl_log_ctrl #(
    parameter int AW    = 32,
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [VPN_W-1:0] vpn,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    limit,
    input  logic             clear,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [VPN_W-1:0] wr_data,
    output logic             irq
);
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] wptr_nx;

    assign wptr_nx = wptr_q + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= base;
            irq     <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= push;
            if (push) begin
                wr_addr <= wptr_q;
                wr_data <= vpn;
                wptr_q  <= wptr_nx;
                if (wptr_nx == limit) irq <= 1'b1;
            end
            if (clear) begin
                wptr_q <= base;
                irq    <= 1'b0;
            end
        end
    end

    // R4: every record lands inside the log region
    p_wr_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr >= base && wr_addr < limit));

    // R6: the interrupt rises together with the last record
    p_irq_on_last_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (wr_en && wr_addr == limit - AW'(1)));

    // R8: acknowledge drops the interrupt
    p_clear_drops_irq_r8: assert property (@(posedge clk) disable iff (rst)
        clear |=> !irq);

endmodule

// File: rtl/tlbmiss_filter_logger.sv
module tlbmiss_filter_logger
    import afl_pkg::*;
#(
    parameter int ENTRIES = 2048,
    parameter int VPN_W   = 20,
    parameter int AW      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    output logic             miss_ready,
    input  logic [AW-1:0]    log_base,
    input  logic [AW-1:0]    log_limit,
    output logic             log_wr_en,
    output logic [AW-1:0]    log_wr_addr,
    output logic [VPN_W-1:0] log_wr_data,
    output logic             irq,
    input  logic             irq_clear
);
    logic buf_hit;
    logic accept;
    act_e act;

    // Filtered pages pass during a pending interrupt; new records wait
    assign miss_ready = !flush && (buf_hit || (!irq && !irq_clear));
    assign accept     = miss_valid && miss_ready;
    assign act        = !accept ? ACT_NONE : (buf_hit ? ACT_HIT : ACT_INSERT);

    afl_active_set #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_set (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .act   (act),
        .vpn   (miss_vpn),
        .hit   (buf_hit)
    );

    afl_log_ctrl #(.AW(AW), .VPN_W(VPN_W)) u_log (
        .clk     (clk),
        .rst     (rst),
        .push    (act == ACT_INSERT),
        .vpn     (miss_vpn),
        .base    (log_base),
        .limit   (log_limit),
        .clear   (irq_clear),
        .wr_en   (log_wr_en),
        .wr_addr (log_wr_addr),
        .wr_data (log_wr_data),
        .irq     (irq)
    );

    // R3: a record only follows a consumed page that missed the set
    p_log_needs_miss_r3: assert property (@(posedge clk) disable iff (rst)
        log_wr_en |-> $past(miss_valid && miss_ready && !buf_hit));

    // R9: after a flush nothing matches
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !buf_hit);

endmodule

// File: tb/tb_tlbmiss_filter_logger.sv
`timescale 1ns/1ps
module tb_tlbmiss_filter_logger;
    localparam int ENTRIES = 4;
    localparam int VPN_W   = 8;
    localparam int AW      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             miss_valid = 1'b0;
    logic [VPN_W-1:0] miss_vpn = '0;
    logic             miss_ready;
    logic [AW-1:0]    log_base  = 8'd16;
    logic [AW-1:0]    log_limit = 8'd24;
    logic             log_wr_en;
    logic [AW-1:0]    log_wr_addr;
    logic [VPN_W-1:0] log_wr_data;
    logic             irq;
    logic             irq_clear = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tlbmiss_filter_logger #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .AW(AW)) dut (
        .clk(clk), .rst(rst), .flush(flush), .miss_valid(miss_valid),
        .miss_vpn(miss_vpn), .miss_ready(miss_ready), .log_base(log_base),
        .log_limit(log_limit), .log_wr_en(log_wr_en), .log_wr_addr(log_wr_addr),
        .log_wr_data(log_wr_data), .irq(irq), .irq_clear(irq_clear)
    );

    // bit 8: record expected; bits 7:0: page number (set size 4, log 16..23)
    localparam logic [8:0] VEC [10] = '{
        9'h111, 9'h122, 9'h011, 9'h133, 9'h144,
        9'h155, 9'h122, 9'h033, 9'h111, 9'h144
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offer one page at a falling edge, let one rising edge pass, check result
    task automatic present(input logic [7:0] v, input bit exp_rdy, input bit exp_log,
                           input logic [7:0] exp_addr, input string req);
        miss_vpn   = v;
        miss_valid = 1'b1;
        #1;
        chk({req, " ready"}, 32'(miss_ready), 32'(exp_rdy));
        @(posedge clk);
        @(negedge clk);
        miss_valid = 1'b0;
        chk({req, " wr_en"}, 32'(log_wr_en), 32'(exp_log));
        if (exp_log) begin
            chk({req, " addr"}, 32'(log_wr_addr), 32'(exp_addr));
            chk({req, " data"}, 32'(log_wr_data), 32'(v));
        end
    endtask

    initial begin
        logic [7:0] ptr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 wr_en", 32'(log_wr_en), 0);
        chk("R1 ready", 32'(miss_ready), 1);

        // R3 R4 R5 R6: filtered and logged pages through LRU eviction
        ptr = 8'd16;
        for (int k = 0; k < 10; k++) begin
            present(VEC[k][7:0], 1'b1, VEC[k][8], ptr, "R4 vec");
            if (VEC[k][8]) ptr++;
        end
        chk("R6 irq at limit", 32'(irq), 1);

        // R7: stall for new pages, filtered pages still pass
        present(8'h55, 1'b0, 1'b0, 8'd0, "R7 stall");
        chk("R7 irq held", 32'(irq), 1);
        present(8'h44, 1'b1, 1'b0, 8'd0, "R7 filtered");

        // R8: clear pulse
        irq_clear  = 1'b1;
        miss_vpn   = 8'h66;
        miss_valid = 1'b1;
        #1;
        chk("R8 ready in clear", 32'(miss_ready), 0);
        @(posedge clk);
        @(negedge clk);
        irq_clear  = 1'b0;
        miss_valid = 1'b0;
        chk("R8 irq dropped", 32'(irq), 0);
        chk("R8 no record", 32'(log_wr_en), 0);
        present(8'h55, 1'b1, 1'b1, 8'd16, "R8 rewound");

        // R5: 22 was least recent and is gone, 11 survives
        present(8'h22, 1'b1, 1'b1, 8'd17, "R5 evicted");
        present(8'h11, 1'b1, 1'b0, 8'd0, "R5 kept");

        // R2: page held without valid is ignored
        miss_vpn = 8'h77;
        @(posedge clk);
        @(negedge clk);
        chk("R2 idle", 32'(log_wr_en), 0);
        present(8'h77, 1'b1, 1'b1, 8'd18, "R2 not installed");

        // R9: flush
        flush      = 1'b1;
        miss_vpn   = 8'h11;
        miss_valid = 1'b1;
        #1;
        chk("R9 ready in flush", 32'(miss_ready), 0);
        @(posedge clk);
        @(negedge clk);
        flush      = 1'b0;
        miss_valid = 1'b0;
        chk("R9 no record", 32'(log_wr_en), 0);
        present(8'h11, 1'b1, 1'b1, 8'd19, "R9 emptied");
        present(8'h77, 1'b1, 1'b1, 8'd20, "R9 emptied2");
        present(8'h11, 1'b1, 1'b0, 8'd0, "R5 refilled hit");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule